// File: doc/BRIEF.md
# External Bus Chip-Select Decoder

This block sits between an internal 32-bit address space and an external memory bus. It holds eight programmable windows. Each window has an enable, a base address, a page size and a data width of 8 or 16 bits. On every request it checks which windows contain the address. It pulls low the active-low select line of every window that matches and produces the 24-bit external address. It reports the access attributes of the governing window. When no enabled window matches, it raises an abort instead, marked as a prefetch or a data abort, with the matching exception vector.

Only the address bits that form the page offset reach the external bus, so a device smaller than its page appears again and again throughout the page. The top four external address pins share package pins with the select lines of windows 4 to 7. While one of those windows is enabled, its pin carries a select line and is no longer driven as an address bit. When several windows match at once, all their select lines go low, and the lowest-numbered one sets the access width. A single-cycle register write port loads the eight window configurations.

Top module: `ebus_cs_decoder`

## Requirements
- R1: After reset, window 0 is enabled with base 0, a 1 MB page and 16-bit width, and windows 1 to 7 are disabled. `cs_n` is all ones, `abort` is 0 and `ext_addr_en` is all ones.
- R2: Decode outputs are registered and reflect the request sampled on the previous rising edge. After a cycle with `req_valid` low, `cs_n` is all ones, `abort` is 0 and `ext_addr`, `acc_wide`, `acc_win` and `abort_vec` are 0.
- R3: Page code 0 selects 1 MB, code 1 selects 2 MB, code 2 selects 4 MB and code 3 selects 16 MB. An enabled window matches when the request address bits above the page size equal the same bits of `{base,20'h0}`; the bits below are ignored.
- R4: A write with `cfg_we` high stores `cfg_data` into window `cfg_sel` at the rising edge. The fields are bit 0 enable, bit 1 width (1 = 16-bit), bits 3:2 page code and bits 15:4 address bits 31:20 of the base. A request in the same cycle is decoded with the configuration as it was before the write.
- R5: On a hit, `ext_addr` holds the request address ANDed with page size minus one, so bits at and above the page size are 0 and a small device aliases through the page.
- R6: When the governing window is 16-bit, `ext_addr[0]` is 0 and `acc_wide` is 1. When it is 8-bit, bit 0 passes through and `acc_wide` is 0.
- R7: Every enabled window that matches drives its `cs_n` bit low. `acc_win` and `acc_wide` come from the lowest-numbered matching window.
- R8: A valid request that matches no enabled window gives `abort` = 1 and `cs_n` all ones, with `ext_addr`, `acc_wide` and `acc_win` at 0. `abort_vec` is 0x0000000C when `req_fetch` is 1 and 0x00000010 otherwise. `abort` and any low `cs_n` bit never appear in the same cycle.
- R9: `ext_addr_en[20+i]` is 0 while window 4+i is enabled, for i = 0 to 3, and all other bits are 1. It follows the configuration from the cycle after a write. A decoded `ext_addr[20+i]` is 0 whenever that pin is in use as a select line.
- R10: A disabled window never matches, whatever its base and page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Window number written |
| cfg_data | input | 16 | Window configuration word |
| req_valid | input | 1 | Access request strobe |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_addr | input | 32 | Internal byte address |
| cs_n | output | 8 | Active-low select lines, one per window |
| ext_addr | output | 24 | External address |
| ext_addr_en | output | 24 | Per-bit flag: external address pin driven as an address |
| acc_wide | output | 1 | Governing window is 16-bit |
| acc_win | output | 3 | Number of the governing window |
| abort | output | 1 | Request matched no enabled window |
| abort_vec | output | 32 | Exception vector for the abort, 0 otherwise |

## Verification
Every decode result (`cs_n`, `ext_addr`, `acc_wide`, `acc_win`, `abort`, `abort_vec`) is due on the first rising edge after the request is sampled. A configuration write alters `ext_addr_en` and the decode of later requests from that same edge on. The bench drives inputs just after the falling edge. It advances a behavioural model on each rising edge, with decode first and the write applied after it, and compares all outputs at the next falling edge. The directed checks sample exactly one falling edge after the request cycle.

// File: rtl/ebus_cs_pkg.sv
package ebus_cs_pkg;

  localparam int NUM_WIN  = 8;
  localparam int ADDR_W   = 32;
  localparam int EXT_AW   = 24;
  localparam int BASE_LSB = 20;
  localparam int BASE_W   = ADDR_W - BASE_LSB;
  localparam int N_SHARED = 4;

  localparam logic [ADDR_W-1:0] VEC_PREFETCH = 32'h0000_000C;
  localparam logic [ADDR_W-1:0] VEC_DATA     = 32'h0000_0010;

  // Field order matches the write word: base[15:4], page[3:2], wide[1], en[0]
  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [1:0]        page;
    logic              wide;
    logic              en;
  } win_cfg_t;

  localparam int CFG_W = $bits(win_cfg_t);

  // Number of page-offset bits for a page code
  function automatic logic [4:0] page_bits(input logic [1:0] code);
    case (code)
      2'd0:    page_bits = 5'd20;
      2'd1:    page_bits = 5'd21;
      2'd2:    page_bits = 5'd22;
      default: page_bits = 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/ebus_cs_cfg_regs.sv
module ebus_cs_cfg_regs
  import ebus_cs_pkg::*;
#(
  parameter int NWIN  = NUM_WIN,
  parameter int IDX_W = $clog2(NWIN)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_sel,
  input  win_cfg_t                   wr_data,
  output win_cfg_t [NWIN-1:0]        cfg_o
);

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    win_cfg_t cfg_q, cfg_d, rst_val;
    logic     load;

    // Window 0 boots enabled: base 0, 1 MB page, 16-bit
    assign rst_val = (k == 0) ? '{base: '0, page: 2'd0, wide: 1'b1, en: 1'b1} : '0;
    assign load    = wr_en && (wr_sel == IDX_W'(k));

    always_comb begin
      cfg_d = cfg_q;
      if (load) cfg_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= rst_val;
      else        cfg_q <= cfg_d;
    end

    assign cfg_o[k] = cfg_q;

    // R4: a write lands in the selected window on the next edge
    assert_cfg_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == IDX_W'(k)) |=> (cfg_q == $past(wr_data)));
  end

endmodule

// File: rtl/ebus_cs_window_match.sv
module ebus_cs_window_match
  import ebus_cs_pkg::*;
#(
  parameter int NWIN = NUM_WIN
) (
  input  logic [ADDR_W-1:0]   addr,
  input  win_cfg_t [NWIN-1:0] cfg_i,
  output logic [NWIN-1:0]     match
);

  for (genvar k = 0; k < NWIN; k++) begin : g_cmp
    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] hi_mask;

    assign base_full = {cfg_i[k].base, {BASE_LSB{1'b0}}};
    assign hi_mask   = ~((ADDR_W'(1) << page_bits(cfg_i[k].page)) - ADDR_W'(1));
    assign match[k]  = cfg_i[k].en && (((addr ^ base_full) & hi_mask) == '0);
  end

endmodule

// File: rtl/ebus_cs_prio_pick.sv
module ebus_cs_prio_pick #(
  parameter int NWIN  = 8,
  parameter int IDX_W = $clog2(NWIN)
) (
  input  logic [NWIN-1:0]  req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = NWIN - 1; k >= 0; k--) begin
      if (req[k]) begin
        found = 1'b1;
        idx   = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/ebus_cs_decoder.sv
module ebus_cs_decoder
  import ebus_cs_pkg::*;
#(
  parameter int NWIN  = NUM_WIN,
  parameter int IDX_W = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              req_valid,
  input  logic              req_fetch,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [NWIN-1:0]   cs_n,
  output logic [EXT_AW-1:0] ext_addr,
  output logic [EXT_AW-1:0] ext_addr_en,
  output logic              acc_wide,
  output logic [IDX_W-1:0]  acc_win,
  output logic              abort,
  output logic [ADDR_W-1:0] abort_vec
);

  localparam int SH_LO = EXT_AW - N_SHARED;
  localparam int CS_LO = NWIN - N_SHARED;

  win_cfg_t [NWIN-1:0] cfg_q;
  logic [NWIN-1:0]     hit_vec;
  logic                hit_any;
  logic [IDX_W-1:0]    hit_idx;
  win_cfg_t            gov;
  logic [ADDR_W-1:0]   off_mask;
  logic [EXT_AW-1:0]   ext_raw;

  logic [NWIN-1:0]     cs_n_d;
  logic [EXT_AW-1:0]   ext_d;
  logic                wide_d, abort_d;
  logic [IDX_W-1:0]    win_d;
  logic [ADDR_W-1:0]   vec_d;

  ebus_cs_cfg_regs #(.NWIN(NWIN), .IDX_W(IDX_W)) i_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (win_cfg_t'(cfg_data)),
    .cfg_o   (cfg_q)
  );

  ebus_cs_window_match #(.NWIN(NWIN)) i_match (
    .addr  (req_addr),
    .cfg_i (cfg_q),
    .match (hit_vec)
  );

  ebus_cs_prio_pick #(.NWIN(NWIN), .IDX_W(IDX_W)) i_pick (
    .req   (hit_vec),
    .found (hit_any),
    .idx   (hit_idx)
  );

  // Upper address pins double as select lines of the upper windows
  for (genvar b = 0; b < EXT_AW; b++) begin : g_pin
    if (b >= SH_LO) begin : g_shared
      assign ext_addr_en[b] = ~cfg_q[b - SH_LO + CS_LO].en;
    end else begin : g_plain
      assign ext_addr_en[b] = 1'b1;
    end
  end

  assign gov      = cfg_q[hit_idx];
  assign off_mask = (ADDR_W'(1) << page_bits(gov.page)) - ADDR_W'(1);

  always_comb begin
    ext_raw = req_addr[EXT_AW-1:0] & off_mask[EXT_AW-1:0];
    if (gov.wide) ext_raw[0] = 1'b0;
    ext_raw = ext_raw & ext_addr_en;
  end

  // Next-state decode
  always_comb begin
    cs_n_d  = '1;
    ext_d   = '0;
    wide_d  = 1'b0;
    win_d   = '0;
    abort_d = 1'b0;
    vec_d   = '0;
    if (req_valid) begin
      if (hit_any) begin
        cs_n_d = ~hit_vec;
        ext_d  = ext_raw;
        wide_d = gov.wide;
        win_d  = hit_idx;
      end else begin
        abort_d = 1'b1;
        vec_d   = req_fetch ? VEC_PREFETCH : VEC_DATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n      <= '1;
      ext_addr  <= '0;
      acc_wide  <= 1'b0;
      acc_win   <= '0;
      abort     <= 1'b0;
      abort_vec <= '0;
    end else begin
      cs_n      <= cs_n_d;
      ext_addr  <= ext_d;
      acc_wide  <= wide_d;
      acc_win   <= win_d;
      abort     <= abort_d;
      abort_vec <= vec_d;
    end
  end

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (cs_n == '1 && !abort && ext_addr == '0));

  assert_abort_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (cs_n == '1));

  assert_abort_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (abort_vec == VEC_PREFETCH || abort_vec == VEC_DATA));

  assert_gov_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |-> !cs_n[acc_win]);

  assert_wide_a0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1 && acc_wide) |-> !ext_addr[0]);

  for (genvar s = SH_LO; s < EXT_AW; s++) begin : g_sh_chk
    assert_shared_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_addr_en[s] |=> !ext_addr[s]);
  end

endmodule

// File: tb/test_ebus_cs_decoder.sv
module test_ebus_cs_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [15:0] cfg_data;
  logic        req_valid, req_fetch;
  logic [31:0] req_addr;
  logic [7:0]  cs_n;
  logic [23:0] ext_addr, ext_addr_en;
  logic        acc_wide, abort;
  logic [2:0]  acc_win;
  logic [31:0] abort_vec;

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_on   = 0;
  bit done     = 0;

  ebus_cs_decoder i_ebus_cs_decoder (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_data, .req_valid, .req_fetch,
    .req_addr, .cs_n, .ext_addr, .ext_addr_en, .acc_wide, .acc_win,
    .abort, .abort_vec
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [11:0] m_base [8];
  logic [1:0]  m_page [8];
  bit          m_wide [8];
  bit          m_en   [8];
  logic [7:0]  e_cs;
  logic [23:0] e_ext;
  bit          e_wide, e_abort;
  int          e_win;
  logic [31:0] e_vec;

  function automatic int shift_of(input logic [1:0] code);
    if (code == 0) return 20;
    if (code == 1) return 21;
    if (code == 2) return 22;
    return 24;
  endfunction

  function automatic logic [23:0] exp_en_mask();
    logic [23:0] m = 24'hFFFFFF;
    for (int i = 0; i < 4; i++) if (m_en[4+i]) m[20+i] = 1'b0;
    return m;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) begin
        m_base[k] = 0; m_page[k] = 0; m_wide[k] = 0; m_en[k] = 0;
      end
      m_en[0] = 1; m_wide[0] = 1;
      e_cs = 8'hFF; e_ext = 0; e_wide = 0; e_abort = 0; e_win = 0; e_vec = 0;
    end else begin
      int first;
      logic [7:0] hits;
      first = -1; hits = 0;
      for (int k = 0; k < 8; k++) begin
        int sh;
        sh = shift_of(m_page[k]);
        if (m_en[k] && ((req_addr >> sh) == ({m_base[k], 20'h0} >> sh))) begin
          hits[k] = 1;
          if (first < 0) first = k;
        end
      end
      e_cs = 8'hFF; e_ext = 0; e_wide = 0; e_abort = 0; e_win = 0; e_vec = 0;
      if (req_valid) begin
        if (first >= 0) begin
          longint off;
          off = longint'(req_addr) % (64'd1 << shift_of(m_page[first]));
          if (m_wide[first]) off = off - (off % 2);
          e_ext  = off[23:0] & exp_en_mask();
          e_cs   = ~hits;
          e_wide = m_wide[first];
          e_win  = first;
        end else begin
          e_abort = 1;
          e_vec   = req_fetch ? 32'hC : 32'h10;
        end
      end
      if (cfg_we) begin
        m_en[cfg_sel]   = cfg_data[0];
        m_wide[cfg_sel] = cfg_data[1];
        m_page[cfg_sel] = cfg_data[3:2];
        m_base[cfg_sel] = cfg_data[15:4];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(cs_n == e_cs, "R3 cs_n", 32'(cs_n), 32'(e_cs));
      chk(ext_addr == e_ext, "R5 ext_addr", 32'(ext_addr), 32'(e_ext));
      chk(acc_wide == e_wide, "R6 acc_wide", 32'(acc_wide), 32'(e_wide));
      chk(acc_win == 3'(e_win), "R7 acc_win", 32'(acc_win), 32'(e_win));
      chk(abort == e_abort, "R8 abort", 32'(abort), 32'(e_abort));
      chk(abort_vec == e_vec, "R8 abort_vec", abort_vec, e_vec);
      chk(ext_addr_en == exp_en_mask(), "R9 ext_addr_en", 32'(ext_addr_en),
          32'(exp_en_mask()));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit we, input logic [2:0] sel, input logic [15:0] d,
                      input bit rv, input bit f, input logic [31:0] a);
    @(negedge clk); #1;
    cfg_we = we; cfg_sel = sel; cfg_data = d;
    req_valid = rv; req_fetch = f; req_addr = a;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  // Request, then sample one falling edge later
  task automatic req_at(input bit f, input logic [31:0] a);
    step(0, 0, 0, 1, f, a);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0;
    cfg_we = 0; cfg_sel = 0; cfg_data = 0;
    req_valid = 0; req_fetch = 0; req_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    // R1: reset state
    chk(cs_n == 8'hFF && !abort, "R1 idle after reset", 32'(cs_n), 32'hFF);
    chk(ext_addr_en == 24'hFFFFFF, "R1 pins free", 32'(ext_addr_en), 32'hFFFFFF);

    // R1 R6: boot window 0 is 16-bit 1 MB at base 0
    req_at(1, 32'h000A_BCDF);
    chk(cs_n == 8'hFE && ext_addr == 24'h0ABCDE && acc_wide,
        "R6 boot window fetch", 32'(ext_addr), 32'h0ABCDE);
    // R8: miss above 1 MB, prefetch then data
    req_at(1, 32'h0010_0000);
    chk(abort && abort_vec == 32'hC && cs_n == 8'hFF, "R8 prefetch abort",
        abort_vec, 32'hC);
    req_at(0, 32'h0030_0000);
    chk(abort && abort_vec == 32'h10, "R8 data abort", abort_vec, 32'h10);
    // R2: idle cycle clears outputs
    idle();
    @(negedge clk);
    chk(cs_n == 8'hFF && !abort && ext_addr == 0, "R2 idle outputs",
        32'(cs_n), 32'hFF);

    // R4: w1 base 0x400 4MB 8-bit; w2 base 0x400 16MB 16-bit; w4 base 0x800 1MB 8-bit
    step(1, 1, 16'h4009, 0, 0, 0);
    step(1, 2, 16'h400F, 0, 0, 0);
    step(1, 4, 16'h8001, 0, 0, 0);
    idle();
    @(negedge clk);
    chk(ext_addr_en == 24'hEFFFFF, "R9 pin A20 taken", 32'(ext_addr_en), 32'hEFFFFF);

    // R7: overlap of w1 and w2, w1 governs
    req_at(0, 32'h4012_3457);
    chk(cs_n == 8'hF9 && acc_win == 1 && !acc_wide, "R7 overlap", 32'(cs_n), 32'hF9);
    chk(ext_addr == 24'h023457, "R9 shared bit zeroed", 32'(ext_addr), 32'h023457);

    // R10: disabling w1 leaves w2 alone
    step(1, 1, 16'h4008, 0, 0, 0);
    req_at(0, 32'h4012_3457);
    chk(cs_n == 8'hFB && acc_win == 2 && acc_wide, "R10 disabled window",
        32'(cs_n), 32'hFB);

    // R4: request in the write cycle sees old config
    step(1, 1, 16'h4009, 1, 0, 32'h4012_3457);
    @(negedge clk);
    chk(cs_n == 8'hFB, "R4 same-cycle write uses old cfg", 32'(cs_n), 32'hFB);
    req_at(0, 32'h4012_3457);
    chk(cs_n == 8'hF9, "R4 write takes effect", 32'(cs_n), 32'hF9);

    // R3: page boundaries
    req_at(0, 32'h4100_0000);
    chk(abort && abort_vec == 32'h10, "R3 beyond 16MB page", 32'(abort), 32'h1);
    req_at(0, 32'h40FF_FFFF);
    chk(cs_n == 8'hFB && ext_addr == 24'hEFFFFE, "R3 top of 16MB page",
        32'(ext_addr), 32'hEFFFFE);

    // R5: aliasing in 8-bit 1MB window 4
    req_at(0, 32'h800F_0001);
    chk(cs_n == 8'hEF && ext_addr == 24'h0F0001 && acc_win == 4,
        "R5 offset only", 32'(ext_addr), 32'h0F0001);

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  hb;
      logic [11:0] bs;
      int r;
      r = $urandom_range(0, 4);
      hb = (r == 0) ? 8'h00 : (r == 1) ? 8'h40 : (r == 2) ? 8'h80 :
           (r == 3) ? 8'h41 : 8'hC0;
      r = $urandom_range(0, 4);
      bs = (r == 0) ? 12'h000 : (r == 1) ? 12'h400 : (r == 2) ? 12'h800 :
           (r == 3) ? 12'hC00 : 12'h410;
      step(($urandom_range(0, 15) == 0), 3'($urandom_range(0, 7)),
           {bs, 4'($urandom_range(0, 15))}, 1'($urandom_range(0, 3) != 0),
           1'($urandom_range(0, 1)), {hb, 24'($urandom())});
    end
    idle();
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule